// File: doc/BRIEF.md
# DRAM Clock-Enable Power State Controller

This block sits on the device side of a DDR-style memory. It follows the clock-enable pin and the command registered at each rising clock edge. It also takes one "row open" bit for each bank. From these inputs it decides whether the device runs normally or sits in one of three low-power states. Power-down with every bank idle is the precharge flavour. Power-down while at least one row is open is the active flavour. Self-refresh is entered with a single command strobe. Its outputs tell the rest of the device whether the internal clock runs, which input receivers stay powered, and whether the output drivers may drive.

Entering and leaving power-down, and entering self-refresh, take effect only on a sampled clock edge. Leaving self-refresh starts asynchronously. The raised clock enable passes through a two-stage synchroniser before the state returns to normal. The output drivers switch off as soon as clock enable falls, with no wait for an edge. The block also watches for two protocol errors: clock enable dropped during a read or write burst, and a self-refresh request while a row is open. Each error sets a sticky flag that stays set until the clear input is sampled high.

Top module: `cke_power_ctrl`

## Requirements
- R1: After synchronous reset, pwr_state is 0 (normal); int_clk_en, ck_rx_en, cmd_rx_en and drv_en are 1; viol_burst and viol_sref are 0.
- R2: In normal state, if an edge samples cke low with cmd not 3 and every bank_open bit 0, pwr_state becomes 1 (precharge power-down). In that state int_clk_en=0, cmd_rx_en=0 and ck_rx_en=1.
- R3: In normal state, if an edge samples cke low with cmd not 3 and any bank_open bit 1, pwr_state becomes 2 (active power-down), with the same gating as R2.
- R4: A change of cke between edges leaves pwr_state unchanged until the next rising edge. From either power-down state, an edge that samples cke high returns pwr_state to 0.
- R5: drv_en is 0 as soon as cke is low, without waiting for a clock edge, and is 0 whenever pwr_state is not 0.
- R6: In normal state, an edge that samples cke low with cmd=3 (self-refresh strobe) and all banks idle makes pwr_state 3 (self-refresh). In that state int_clk_en, ck_rx_en, cmd_rx_en and drv_en are all 0.
- R7: In self-refresh, after cke rises pwr_state stays 3 through the first two rising edges that sample cke high and becomes 0 after the third.
- R8: A self-refresh strobe (cke low, cmd=3) while any bank is open does not enter self-refresh. It sets viol_sref and enters active power-down.
- R9: A read (cmd=1) or write (cmd=2) sampled with cke high opens a burst of BURST_LEN edges (default 4). An edge that samples cke low within those edges sets viol_burst. An edge that samples cke low after the burst has ended does not.
- R10: viol_burst and viol_sref stay set until an edge samples viol_clr high, which clears both.
- R11: In a power-down state the cmd input is ignored. A self-refresh strobe there neither changes pwr_state nor sets viol_sref.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cmd | input | 2 | Registered command: 0 none, 1 read, 2 write, 3 self-refresh strobe |
| bank_open | input | NUM_BANKS | One bit per bank, 1 while a row is open |
| viol_clr | input | 1 | Clears both violation flags when sampled high |
| pwr_state | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self-refresh |
| int_clk_en | output | 1 | Internal clock enable |
| ck_rx_en | output | 1 | Clock-pair receiver enable |
| cmd_rx_en | output | 1 | Enable for all other input receivers except clock enable |
| drv_en | output | 1 | Output driver enable |
| viol_burst | output | 1 | Sticky: clock enable dropped during a burst |
| viol_sref | output | 1 | Sticky: self-refresh requested with a row open |

## Verification
Clock enable is dropped with all banks idle and again with one bank open, which separates the two power-down flavours. The self-refresh strobe is given with idle banks and again with an open bank, which separates a legal entry from the violation path. Clock enable is toggled between edges to show that state moves only on edges while the drivers react at once. It is also raised in self-refresh and the state is watched edge by edge to confirm the synchroniser delay. Clock enable is dropped on the last edge of a burst and again on the first edge after it, which pins the burst window exactly.

// File: rtl/ckepwr_pkg.sv
package ckepwr_pkg;

    typedef enum logic [1:0] {
        PS_NORMAL = 2'd0,
        PS_PRE_PD = 2'd1,
        PS_ACT_PD = 2'd2,
        PS_SREF   = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_SREF  = 2'd3
    } cmd_e;

    typedef struct packed {
        logic int_clk;
        logic ck_rx;
        logic cmd_rx;
        logic drv;
    } gate_t;

    function automatic logic is_access(cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

    function automatic gate_t gates_for(pwr_state_e s);
        gate_t g;
        g.int_clk = (s == PS_NORMAL);
        g.ck_rx   = (s != PS_SREF);
        g.cmd_rx  = (s == PS_NORMAL);
        g.drv     = (s == PS_NORMAL);
        return g;
    endfunction

endpackage

// File: rtl/cke_sync.sv
module cke_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic all_high
);
    logic [STAGES-1:0] chain_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // Exit only after every stage has seen the input high.
    assign all_high = &chain_q;
endmodule

// File: rtl/cke_burst_tracker.sv
module cke_burst_tracker #(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic flush,
    output logic busy
);
    localparam int CW = $clog2(BURST_LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(BURST_LEN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush)      cnt_q <= '0;
        else if (start)        cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    assert_load_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !flush) |=> busy);
endmodule

// File: rtl/cke_power_fsm.sv
module cke_power_fsm
    import ckepwr_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  cmd_e                 cmd,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 viol_clr,
    input  logic                 sync_high,
    input  logic                 burst_busy,
    output pwr_state_e           state,
    output logic                 burst_start,
    output logic                 burst_flush,
    output logic                 viol_burst,
    output logic                 viol_sref
);
    pwr_state_e st_q, st_d;
    logic any_open;
    logic set_burst, set_sref;
    logic vb_q, vs_q;

    assign any_open = |bank_open;

    always_comb begin
        st_d      = st_q;
        set_burst = 1'b0;
        set_sref  = 1'b0;
        case (st_q)
            PS_NORMAL: begin
                if (!cke) begin
                    if (burst_busy) set_burst = 1'b1;
                    if (cmd == CMD_SREF) begin
                        if (any_open) begin
                            set_sref = 1'b1;
                            st_d     = PS_ACT_PD;
                        end else begin
                            st_d = PS_SREF;
                        end
                    end else begin
                        st_d = any_open ? PS_ACT_PD : PS_PRE_PD;
                    end
                end
            end
            PS_PRE_PD, PS_ACT_PD: begin
                if (cke) st_d = PS_NORMAL;
            end
            PS_SREF: begin
                if (sync_high) st_d = PS_NORMAL;
            end
            default: st_d = PS_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PS_NORMAL;
            vb_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (set_burst)     vb_q <= 1'b1;
            else if (viol_clr) vb_q <= 1'b0;
            if (set_sref)      vs_q <= 1'b1;
            else if (viol_clr) vs_q <= 1'b0;
        end
    end

    assign state       = st_q;
    assign burst_start = (st_q == PS_NORMAL) && cke && is_access(cmd);
    assign burst_flush = (st_q == PS_NORMAL) && !cke;
    assign viol_burst  = vb_q;
    assign viol_sref   = vs_q;

    assert_pre_pd_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_NORMAL && !cke && cmd != CMD_SREF && !any_open) |=> st_q == PS_PRE_PD);

    assert_act_pd_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_NORMAL && !cke && any_open) |=> st_q == PS_ACT_PD);

    assert_pd_exit_R4: assert property (@(posedge clk) disable iff (rst)
        ((st_q == PS_PRE_PD || st_q == PS_ACT_PD) && cke) |=> st_q == PS_NORMAL);

    assert_sref_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q != PS_SREF && any_open) |=> st_q != PS_SREF);

    assert_sref_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_SREF && !$past(cke)) |=> st_q == PS_SREF);

    assert_burst_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_NORMAL && !cke && burst_busy) |=> vb_q);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (vb_q && !viol_clr) |=> vb_q);

    assert_pd_cmd_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_PRE_PD && !cke) |=> (st_q == PS_PRE_PD && $stable(vs_q)));
endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl
    import ckepwr_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BURST_LEN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic [1:0]           cmd,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 viol_clr,
    output logic [1:0]           pwr_state,
    output logic                 int_clk_en,
    output logic                 ck_rx_en,
    output logic                 cmd_rx_en,
    output logic                 drv_en,
    output logic                 viol_burst,
    output logic                 viol_sref
);
    pwr_state_e st;
    gate_t      gates;
    logic       sync_high, busy, b_start, b_flush;

    cke_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(cke), .all_high(sync_high)
    );

    cke_burst_tracker #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk(clk), .rst(rst), .start(b_start), .flush(b_flush), .busy(busy)
    );

    cke_power_fsm #(.NUM_BANKS(NUM_BANKS)) u_fsm (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd_e'(cmd)),
        .bank_open(bank_open), .viol_clr(viol_clr),
        .sync_high(sync_high), .burst_busy(busy), .state(st),
        .burst_start(b_start), .burst_flush(b_flush),
        .viol_burst(viol_burst), .viol_sref(viol_sref)
    );

    assign gates      = gates_for(st);
    assign pwr_state  = st;
    assign int_clk_en = gates.int_clk;
    assign ck_rx_en   = gates.ck_rx;
    assign cmd_rx_en  = gates.cmd_rx;
    // Driver shut-off follows the pin directly, without waiting for an edge.
    assign drv_en     = gates.drv & cke;

    assert_drv_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!cke || pwr_state != 2'd0) |-> !drv_en);

    assert_sref_gating_R6: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd3) |-> (!ck_rx_en && !cmd_rx_en && !int_clk_en));
endmodule

// File: tb/cke_power_ctrl_tb.sv
module cke_power_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst, cke, viol_clr;
    logic [1:0] cmd;
    logic [3:0] bank_open;
    logic [1:0] pwr_state;
    logic       int_clk_en, ck_rx_en, cmd_rx_en, drv_en, viol_burst, viol_sref;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cke_power_ctrl u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .bank_open(bank_open),
        .viol_clr(viol_clr), .pwr_state(pwr_state), .int_clk_en(int_clk_en),
        .ck_rx_en(ck_rx_en), .cmd_rx_en(cmd_rx_en), .drv_en(drv_en),
        .viol_burst(viol_burst), .viol_sref(viol_sref)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; cke = 1; cmd = 0; bank_open = 0; viol_clr = 0;
        step(); step();
        rst = 0;
        step();
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 state", pwr_state, 0);
        chk("R1 gates", {int_clk_en, ck_rx_en, cmd_rx_en, drv_en}, 4'b1111);
        chk("R1 flags", {viol_burst, viol_sref}, 0);
    endtask

    task automatic t_pre_pd();
        do_reset();
        cke = 0; step();
        chk("R2 state", pwr_state, 1);
        chk("R2 gates", {int_clk_en, ck_rx_en, cmd_rx_en, drv_en}, 4'b0100);
        cke = 1; step();
        chk("R4 exit", pwr_state, 0);
    endtask

    task automatic t_act_pd();
        do_reset();
        bank_open = 4'b0100; cke = 0; step();
        chk("R3 state", pwr_state, 2);
        chk("R3 gates", {int_clk_en, ck_rx_en, cmd_rx_en, drv_en}, 4'b0100);
        cke = 1; step();
        chk("R4 exit act", pwr_state, 0);
    endtask

    task automatic t_edge_only();
        do_reset();
        cke = 0; #2;
        chk("R4 no change between edges", pwr_state, 0);
        chk("R5 drv off at once", drv_en, 0);
        step();
        chk("R4 entry at edge", pwr_state, 1);
        cke = 1; #2;
        chk("R4 still pd between edges", pwr_state, 1);
        chk("R5 drv off in pd", drv_en, 0);
        step();
        chk("R5 drv back", drv_en, 1);
    endtask

    task automatic t_sref();
        do_reset();
        cke = 0; cmd = 3; step();
        cmd = 0;
        chk("R6 state", pwr_state, 3);
        chk("R6 gates", {int_clk_en, ck_rx_en, cmd_rx_en, drv_en}, 4'b0000);
        step(); step();
        chk("R7 hold while low", pwr_state, 3);
        cke = 1; step(); step();
        chk("R7 still sref after two edges", pwr_state, 3);
        step();
        chk("R7 normal after third edge", pwr_state, 0);
        chk("R7 no sref flag", viol_sref, 0);
    endtask

    task automatic t_sref_open();
        do_reset();
        bank_open = 4'b0001; cke = 0; cmd = 3; step();
        cmd = 0;
        chk("R8 state", pwr_state, 2);
        chk("R8 flag", viol_sref, 1);
    endtask

    task automatic t_burst_viol();
        do_reset();
        cmd = 1; step();
        cmd = 0; step(); step(); step();
        cke = 0; step();
        chk("R9 drop on last burst edge", viol_burst, 1);
        chk("R9 pd entered", pwr_state, 1);
        cke = 1; step(); step();
        chk("R10 sticky", viol_burst, 1);
        viol_clr = 1; step();
        viol_clr = 0;
        chk("R10 cleared", viol_burst, 0);
    endtask

    task automatic t_burst_ok();
        do_reset();
        cmd = 2; step();
        cmd = 0; step(); step(); step(); step();
        cke = 0; step();
        chk("R9 drop after burst", viol_burst, 0);
        chk("R9 state", pwr_state, 1);
    endtask

    task automatic t_pd_ignore();
        do_reset();
        cke = 0; step();
        cmd = 3; step();
        chk("R11 stays pre pd", pwr_state, 1);
        chk("R11 no flag", viol_sref, 0);
        cmd = 0;
    endtask

    initial begin
        t_reset_state();
        t_pre_pd();
        t_act_pd();
        t_edge_only();
        t_sref();
        t_sref_open();
        t_burst_viol();
        t_burst_ok();
        t_pd_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule